// File: doc/BRIEF.md
# SPI Master Burst Transfer Engine

A register-programmed SPI master that runs one chip-select burst per start command. Software programs two byte counts. The burst length is the total number of bytes to clock. The transmit length is how many of those bytes are taken from a 64-entry transmit FIFO. Once the transmit length is used up, the engine keeps clocking and drives a fixed dummy byte until the burst length is reached.

Every byte shifted in from the slave is stored in a 64-entry receive FIFO. This includes the bytes that arrive while command or address bytes go out, so software discards the leading bytes it does not need. The serial clock runs at a quarter of the module clock in mode 0. A programmable idle time separates consecutive bursts. A soft reset and per-FIFO flush controls return the engine to a known state.

Register map (byte offsets): 0x00 control, 0x04 burst length, 0x08 transmit length, 0x0C status, 0x10 transmit data (write pushes), 0x14 receive data (read pops), 0x18 chip-select idle time.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, and the control and status registers read 0.
- R2: A burst keeps spi_cs_n low throughout and clocks exactly the programmed burst length in bytes. Each byte takes 8 rising SCK edges and is sent most significant bit first.
- R3: The first min(transmit length, TX FIFO content) bytes of a burst are popped from the TX FIFO in write order. Every later byte is sent as the dummy value 0x00.
- R4: Every byte received during a burst is written to the RX FIFO in order, including bytes received while TX FIFO data was sent. A read of offset 0x14 returns and pops the oldest byte. Status bits [6:0] give the RX fill level, from 0 to 64.
- R5: Writing 1 to control bit 10 requests a burst. The request is held pending until control bit 0 (enable) and bit 1 (master) are both 1. Bit 10 reads 1 until the last byte has been clocked and then clears itself. With a burst length of 0, it clears without any chip-select activity.
- R6: SCK is the module clock divided by 4 and idles low. MOSI changes only while SCK is low, and MISO is sampled on the rising edge of SCK.
- R7: Between two bursts, spi_cs_n stays high for at least the number of module clocks held in the idle-time register. A request made during that time waits.
- R8: Writing 1 to control bit 8 empties the TX FIFO, and writing 1 to bit 9 empties the RX FIFO. Both bits read 0.
- R9: Writing 1 to control bit 31 starts a soft reset. The bit reads 1 for SRST_CYCLES module clocks and then clears. The soft reset aborts a running burst, releases spi_cs_n, clears bit 10 and empties both FIFOs, while enable and master are kept.
- R10: A write to the TX FIFO while it holds 64 bytes is dropped. A byte received while the RX FIFO holds 64 bytes is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX data at 0x14) |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A wrong byte index or a missed pop in the engine shows on MOSI within one byte time, 32 module clocks, as a shifted or repeated command byte. The same fault leaves the RX fill level different from the burst length once the exchange bit clears. A bad phase counter breaks the four-clock SCK period at the first bit. A stuck exchange bit or idle counter shows as a burst that never ends or a chip-select gap shorter than programmed. A soft reset that fails to clear state leaves a nonzero fill level or a low chip select right after bit 31 clears.

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 8,
  parameter int GAP_W = 8,
  parameter int SRST_CYCLES = 4,
  parameter logic [7:0] DUMMY = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = PW + 1;
  localparam int SW = $clog2(SRST_CYCLES + 1);
  localparam logic [4:0] A_CTRL = 5'h00, A_BURST = 5'h04, A_TXN = 5'h08,
                         A_STAT = 5'h0C, A_TXD = 5'h10, A_RXD = 5'h14, A_GAP = 5'h18;

  logic en, mst, xch, busy;
  logic [CNT_W-1:0] burst_r, txn_r, idx, idx_nx, ld_idx;
  logic [GAP_W-1:0] gap_r, gap_cnt;
  logic [SW-1:0] srst_cnt;
  logic [1:0] ph;
  logic [2:0] bitn;
  logic [7:0] tsh, rsh;

  logic [7:0] tx_mem [DEPTH];
  logic [7:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_cnt, rx_cnt;

  logic srst, srst_go, kill, wr_ctrl, start, byte_end, last, load, tx_take;
  logic tx_push, tx_pop, rx_push, rx_pop, tx_flush, rx_flush;
  logic unused_wdata;

  assign srst     = srst_cnt != '0;
  assign wr_ctrl  = reg_wr && reg_addr == A_CTRL && !srst;
  assign srst_go  = wr_ctrl && reg_wdata[31];
  assign kill     = srst_go || srst;
  assign tx_flush = kill || (wr_ctrl && reg_wdata[8]);
  assign rx_flush = kill || (wr_ctrl && reg_wdata[9]);

  assign start    = xch && !busy && gap_cnt == '0 && en && mst && !srst;
  assign byte_end = busy && ph == 2'd3 && bitn == 3'd7;
  assign idx_nx   = idx + CNT_W'(1);
  assign last     = byte_end && idx_nx == burst_r;
  assign load     = (start && burst_r != '0) || (byte_end && !last);
  assign ld_idx   = start ? '0 : idx_nx;
  assign tx_take  = load && ld_idx < txn_r && tx_cnt != '0;

  assign tx_push  = reg_wr && reg_addr == A_TXD && !srst && tx_cnt != LW'(DEPTH);
  assign tx_pop   = tx_take;
  assign rx_push  = byte_end && rx_cnt != LW'(DEPTH);
  assign rx_pop   = reg_rd && reg_addr == A_RXD && rx_cnt != '0;

  assign spi_sck  = busy & ph[1];
  assign spi_mosi = busy & tsh[7];
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; mst <= 1'b0; xch <= 1'b0; busy <= 1'b0; spi_cs_n <= 1'b1;
      burst_r <= '0; txn_r <= '0; gap_r <= '0; gap_cnt <= '0; srst_cnt <= '0;
      idx <= '0; ph <= '0; bitn <= '0; tsh <= '0; rsh <= '0;
    end else begin
      if (srst) srst_cnt <= srst_cnt - SW'(1);
      if (gap_cnt != '0) gap_cnt <= gap_cnt - GAP_W'(1);
      if (reg_wr && !srst) begin
        case (reg_addr)
          A_BURST: burst_r <= reg_wdata[CNT_W-1:0];
          A_TXN:   txn_r   <= reg_wdata[CNT_W-1:0];
          A_GAP:   gap_r   <= reg_wdata[GAP_W-1:0];
          default: ;
        endcase
      end
      if (busy) begin
        ph <= ph + 2'd1;
        if (ph == 2'd1) rsh <= {rsh[6:0], spi_miso};
        if (ph == 2'd3 && bitn != 3'd7) begin
          tsh  <= {tsh[6:0], 1'b0};
          bitn <= bitn + 3'd1;
        end
      end
      if (last) begin
        busy <= 1'b0; spi_cs_n <= 1'b1; xch <= 1'b0; gap_cnt <= gap_r;
      end
      if (start && burst_r == '0) xch <= 1'b0;
      if (load) begin
        tsh  <= tx_take ? tx_mem[tx_rp] : DUMMY;
        bitn <= '0; idx <= ld_idx; busy <= 1'b1; spi_cs_n <= 1'b0;
      end
      if (wr_ctrl) begin
        en  <= reg_wdata[0];
        mst <= reg_wdata[1];
        if (reg_wdata[10]) xch <= 1'b1;
      end
      if (srst_go) begin
        srst_cnt <= SW'(SRST_CYCLES);
        busy <= 1'b0; spi_cs_n <= 1'b1; xch <= 1'b0; ph <= '0; gap_cnt <= gap_r;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rsh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + PW'(1);
      if (tx_pop)  tx_rp <= tx_rp + PW'(1);
      tx_cnt <= tx_cnt + LW'(tx_push) - LW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + PW'(1);
      if (rx_pop)  rx_rp <= rx_rp + PW'(1);
      rx_cnt <= rx_cnt + LW'(rx_push) - LW'(rx_pop);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = {srst, 20'b0, xch, 8'b0, mst, en};
      A_BURST: reg_rdata = 32'(burst_r);
      A_TXN:   reg_rdata = 32'(txn_r);
      A_STAT:  reg_rdata = 32'(rx_cnt);
      A_RXD:   reg_rdata = (rx_cnt != '0) ? 32'(rx_mem[rx_rp]) : '0;
      A_GAP:   reg_rdata = 32'(gap_r);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_burst_master_chk.sv
`timescale 1ns/1ps
module spi_burst_master_chk #(
  parameter int DEPTH = 64,
  parameter int LW = 7,
  parameter int GAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_sck,
  input logic             spi_cs_n,
  input logic             spi_mosi,
  input logic             xch,
  input logic             srst_busy,
  input logic [LW-1:0]    rx_level,
  input logic [GAP_W-1:0] gap_val
);
  logic [GAP_W:0]   hi_cnt;
  logic [GAP_W-1:0] gap_cap;
  logic             armed, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0; gap_cap <= '0; armed <= 1'b0; cs_q <= 1'b1;
    end else begin
      cs_q <= spi_cs_n;
      if (!spi_cs_n) hi_cnt <= '0;
      else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      if (spi_cs_n && !cs_q) begin
        armed <= 1'b1;
        gap_cap <= gap_val;
      end
    end
  end

  a_r2_sck_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n);
  a_r5_cs_low_needs_xch: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> xch);
  a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));
  a_r6_sck_high_two: assert property (@(posedge clk) disable iff (!rst_n || srst_busy)
    $rose(spi_sck) |=> spi_sck ##1 !spi_sck);
  a_r7_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(spi_cs_n)) |-> hi_cnt >= {1'b0, gap_cap});
  a_r9_srst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> (spi_cs_n && !xch));
  a_r10_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH));
endmodule

bind spi_burst_master spi_burst_master_chk #(.DEPTH(DEPTH), .LW(LW), .GAP_W(GAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
  .xch(xch), .srst_busy(srst), .rx_level(rx_cnt), .gap_val(gap_r));

// File: tb/spi_burst_master_tb.sv
`timescale 1ns/1ps
module spi_burst_master_tb;
  localparam int CLK_P = 10;
  localparam logic [4:0] A_CTRL = 5'h00, A_BURST = 5'h04, A_TXN = 5'h08,
                         A_STAT = 5'h0C, A_TXD = 5'h10, A_RXD = 5'h14, A_GAP = 5'h18;
  // {burst, txn, seed}
  localparam logic [23:0] VEC [5] = '{24'h05_04_11, 24'h01_01_22, 24'h03_00_33,
                                       24'h08_08_44, 24'h0C_02_55};

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0, spi_miso = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic spi_sck, spi_cs_n, spi_mosi;
  int errors = 0, checks = 0;

  spi_burst_master u_dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] resp(input logic [7:0] s, input int k);
    return s ^ 8'(k * 29 + 5);
  endfunction
  function automatic logic [7:0] txb(input logic [7:0] s, input int j);
    return 8'(s * 3 + j * 17 + 1);
  endfunction

  // slave model
  logic [7:0] slave_seed = 8'h00, msh = '0;
  logic [7:0] mon [128];
  int sb_bit = 0, sb_byte = 0, n_fall = 0, n_rise = 0;
  logic cs_prev = 1'b1, sck_prev = 1'b0;
  realtime t_rise = 0, hi_time = 0, t_sck0 = 0, t_sck1 = 0;

  always @(spi_cs_n or spi_sck) begin
    if (spi_cs_n !== cs_prev) begin
      if (spi_cs_n === 1'b0) begin
        sb_bit = 0; sb_byte = 0; n_fall++;
        hi_time = $realtime - t_rise;
        spi_miso = resp(slave_seed, 0)[7];
      end else t_rise = $realtime;
      cs_prev = spi_cs_n;
    end
    if (spi_sck !== sck_prev) begin
      if (spi_sck === 1'b1 && spi_cs_n === 1'b0) begin
        if (n_rise == 0) t_sck0 = $realtime;
        if (n_rise == 1) t_sck1 = $realtime;
        n_rise++;
        msh = {msh[6:0], spi_mosi};
        sb_bit++;
        if (sb_bit == 8) begin
          if (sb_byte < 128) mon[sb_byte] = msh;
          sb_byte++; sb_bit = 0;
        end
      end else if (spi_sck === 1'b0 && spi_cs_n === 1'b0) begin
        spi_miso = resp(slave_seed, sb_byte)[7 - sb_bit];
      end
      sck_prev = spi_sck;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic pop, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = pop;
    #(CLK_P/4) d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] d;
    for (int i = 0; i < 5000; i++) begin
      rd(A_CTRL, 0, d);
      if (!d[10]) return;
    end
    chk(req, 32'hdead, 32'h0);
  endtask

  initial begin
    #(200000 * CLK_P);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int b, t, n, f0;
    logic [7:0] s;
    #(3 * CLK_P + 2) rst_n = 1;
    @(negedge clk);
    chk("R1 cs_n", 32'(spi_cs_n), 1);
    chk("R1 sck", 32'(spi_sck), 0);
    rd(A_CTRL, 0, d); chk("R1 ctrl", d, 0);
    rd(A_STAT, 0, d); chk("R1 status", d, 0);

    wr(A_CTRL, 32'h3);
    foreach (VEC[v]) begin
      b = int'(VEC[v][23:16]); t = int'(VEC[v][15:8]); s = VEC[v][7:0];
      slave_seed = s;
      wr(A_BURST, 32'(b)); wr(A_TXN, 32'(t));
      for (int j = 0; j < t; j++) wr(A_TXD, 32'(txb(s, j)));
      wr(A_CTRL, 32'h403);
      wait_idle("R5 exchange clears");
      chk("R2 byte count", 32'(sb_byte), 32'(b));
      for (int j = 0; j < b; j++)
        chk("R3 mosi byte", 32'(mon[j]), 32'(j < t ? txb(s, j) : 8'h00));
      rd(A_STAT, 0, d); chk("R4 rx level", d, 32'(b));
      for (int k = 0; k < b; k++) begin
        rd(A_RXD, 1, d); chk("R4 rx byte", d, 32'(resp(s, k)));
      end
      rd(A_STAT, 0, d); chk("R4 rx drained", d, 0);
      if (v == 0) begin
        chk("R6 sck period", 32'(int'((t_sck1 - t_sck0) / CLK_P)), 4);
        chk("R6 sck idle low", 32'(spi_sck), 0);
      end
    end

    // R5 pending while disabled
    slave_seed = 8'h66; f0 = n_fall;
    wr(A_BURST, 2); wr(A_TXN, 0);
    wr(A_CTRL, 32'h400);
    repeat (40) @(negedge clk);
    chk("R5 no burst while disabled", 32'(n_fall - f0), 0);
    rd(A_CTRL, 0, d); chk("R5 request pending", d, 32'h400);
    wr(A_CTRL, 32'h403);
    wait_idle("R5 pending completes");
    chk("R5 pending burst bytes", 32'(sb_byte), 2);
    // R8 flush bits
    wr(A_CTRL, 32'h303);
    rd(A_CTRL, 0, d); chk("R8 flush bits read 0", d, 32'h3);
    rd(A_STAT, 0, d); chk("R8 rx flushed", d, 0);

    // R5 zero-length burst
    f0 = n_fall;
    wr(A_BURST, 0); wr(A_CTRL, 32'h403);
    repeat (3) @(negedge clk);
    rd(A_CTRL, 0, d); chk("R5 zero burst clears", d, 32'h3);
    chk("R5 zero burst no cs", 32'(n_fall - f0), 0);

    // R8 tx flush
    slave_seed = 8'h77;
    for (int j = 0; j < 3; j++) wr(A_TXD, 32'h5A);
    wr(A_CTRL, 32'h103);
    wr(A_BURST, 2); wr(A_TXN, 2); wr(A_CTRL, 32'h403);
    wait_idle("R8 burst");
    chk("R8 tx flushed byte0", 32'(mon[0]), 0);
    chk("R8 tx flushed byte1", 32'(mon[1]), 0);
    wr(A_CTRL, 32'h203);

    // R7 idle gap
    wr(A_GAP, 20); wr(A_BURST, 1); wr(A_TXN, 0);
    wr(A_CTRL, 32'h403);
    @(posedge spi_cs_n);
    wr(A_CTRL, 32'h403);
    wait_idle("R7 second burst");
    n = int'(hi_time / CLK_P);
    chk("R7 gap at least", 32'(n >= 20), 1);
    chk("R7 gap not excessive", 32'(n <= 23), 1);
    rd(A_STAT, 0, d); chk("R7 both bursts received", d, 2);
    wr(A_CTRL, 32'h203);

    // R9 soft reset
    wr(A_BURST, 40); wr(A_TXN, 0); wr(A_CTRL, 32'h403);
    repeat (30) @(negedge clk);
    wr(A_CTRL, 32'h80000003);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      rd(A_CTRL, 0, d);
      if (d[31]) n++; else break;
    end
    chk("R9 srst busy cycles", 32'(n), 4);
    chk("R9 ctrl after srst", d, 32'h3);
    chk("R9 cs released", 32'(spi_cs_n), 1);
    rd(A_STAT, 0, d); chk("R9 rx emptied", d, 0);

    // R10 overflow
    slave_seed = 8'h88;
    wr(A_GAP, 2);
    for (int j = 0; j < 70; j++) wr(A_TXD, 32'(txb(8'h99, j)));
    wr(A_BURST, 70); wr(A_TXN, 70); wr(A_CTRL, 32'h403);
    wait_idle("R10 burst");
    chk("R10 burst bytes", 32'(sb_byte), 70);
    chk("R10 last stored tx", 32'(mon[63]), 32'(txb(8'h99, 63)));
    chk("R10 dropped tx gives dummy", 32'(mon[64]), 0);
    chk("R10 dummy tail", 32'(mon[69]), 0);
    rd(A_STAT, 0, d); chk("R10 rx level capped", d, 64);
    for (int k = 0; k < 64; k++) begin
      rd(A_RXD, 1, d); chk("R10 rx byte", d, 32'(resp(8'h88, k)));
    end
    rd(A_STAT, 0, d); chk("R10 rx drained", d, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule